// File: doc/BRIEF.md
# Ratio-Selectable Synchronous Clock Divider Tree

This block produces a family of phase-related clocks from one fast internal clock. The fast clock is nominally 400 MHz. The block generates five groups of outputs: a processor clock, a memory reference clock at half the processor rate, a 66 MHz bus clock, a 33 MHz bus clock and an interrupt-controller clock. A frequency-select input picks between a 133 MHz and a 100 MHz processor clock. The block adjusts the other division ratios so that the 66 MHz and 33 MHz groups stay fixed in frequency. A strap sampled during reset chooses whether the interrupt-controller clock is fixed at 16.67 MHz or runs at a quarter of the processor clock.

All ratios come from one shared phase counter with a 48-cycle frame. Every ratio divides 48, so the start of each frame is a common rising point for all groups. Ratio changes and stop/run changes are taken only at that frame boundary. A second strap, also sampled during reset, can hold the last two copies of the processor and interrupt-controller groups low. A stop input holds every output low.

Top module: `clkdiv_tree`

## Requirements
- R1: With `sel_fast`=1 the processor outputs have a period of 3 fast cycles. With `sel_fast`=0 the period is 4 fast cycles.
- R2: The memory reference outputs have a period of twice the processor period (6 or 8 fast cycles). Each of their rising edges coincides with a processor rising edge.
- R3: The 66 MHz outputs have a period of 6 fast cycles and the 33 MHz outputs a period of 12 fast cycles, for either value of `sel_fast`.
- R4: With `apic_strap` captured as 0, the interrupt-controller period is 24 fast cycles. With it captured as 1, the period is 4 times the processor period (12 or 16).
- R5: Every output is high for exactly half of its period when counted in half fast cycles. The 3-cycle processor clock is high for 1.5 cycles because a falling-edge stage stretches it.
- R6: Each 33 MHz rising edge comes exactly one fast cycle after a rising edge of both the processor and the 66 MHz outputs. Each interrupt-controller rising edge comes exactly one fast cycle after a processor rising edge.
- R7: `wide_strap` is captured while `rst_n` is low. When it is captured as 0, processor copies 5 and 6 and interrupt-controller copies 5 and 6 stay low. When it is captured as 1, all copies of a group are identical. Changing the strap after reset has no effect.
- R8: `apic_strap` is captured only while `rst_n` is low. Changing it after reset does not alter the interrupt-controller period.
- R9: A change of `sel_fast` is applied only at a 48-cycle frame boundary. Across the change, processor intervals are only 3 or 4 cycles, interrupt-controller intervals with the strap at 1 are only 12 or 16 cycles, and the 33 MHz period stays 12.
- R10: `stop_req` passes through a two-stage synchronizer and takes effect at a frame boundary. While it is stopped, every output is low. After release, the outputs run again at their selected ratios.
- R11: All outputs are low while `rst_n` is low. They stay low until the first frame boundary after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Asynchronous active-low reset; straps are captured while low |
| sel_fast | input | 1 | 1 selects the 133 MHz processor clock, 0 the 100 MHz clock |
| apic_strap | input | 1 | 1 selects processor/4 for the interrupt-controller clock, 0 selects the fixed 16.67 MHz |
| wide_strap | input | 1 | 1 enables all seven processor and interrupt-controller copies, 0 holds copies 5 and 6 low |
| stop_req | input | 1 | Asynchronous request to hold all outputs low |
| cpu_clk | output | 7 | Processor clock copies |
| memref_clk | output | 2 | Memory reference clock copies at half the processor rate |
| pci66_clk | output | 4 | Fixed 66 MHz copies |
| pci33_clk | output | 2 | Fixed 33 MHz copies |
| apic_clk | output | 7 | Interrupt-controller clock copies |

## Verification
Both control inputs reach the outputs with a known delay:
- Two synchronizer stages.
- A wait of up to 48 cycles for the frame boundary.
- One output register, or a half cycle more for the stretched edge.

The worst case is 51 cycles. The bench therefore waits at least 60 fast cycles after every reset release, stop edge or select edge before it opens a measurement window. Each window is a multiple of 48 cycles.

The outputs are sampled a quarter and three quarters of the way through each fast cycle. This keeps every sample clear of both clock edges. The early sample also shows the falling-edge stretch.

The checks that cover a select change are written over a window that spans the frame boundary. They accept only the old or the new interval.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int unsigned FRAME_LEN        = 48;
  localparam int unsigned PHASE_W          = $clog2(FRAME_LEN);
  localparam int unsigned RATIO_W          = $clog2(FRAME_LEN + 1);
  localparam int unsigned PCI66_RATIO      = 6;
  localparam int unsigned PCI33_RATIO      = 12;
  localparam int unsigned APIC_FIXED_RATIO = 24;
  localparam int unsigned LATE_LAG         = 1;

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    ratio_t cpu;
    ratio_t mem;
    ratio_t pci66;
    ratio_t pci33;
    ratio_t apic;
  } ratio_set_t;

  // Processor division from the fast clock: 3 for 133 MHz, 4 for 100 MHz.
  function automatic ratio_t cpu_ratio(input logic fast);
    return fast ? ratio_t'(3) : ratio_t'(4);
  endfunction

  function automatic ratio_set_t ratios(input logic fast, input logic apic_cpu4);
    ratio_set_t r;
    r.cpu   = cpu_ratio(fast);
    r.mem   = ratio_t'(2 * 32'(r.cpu));
    r.pci66 = ratio_t'(PCI66_RATIO);
    r.pci33 = ratio_t'(PCI33_RATIO);
    r.apic  = apic_cpu4 ? ratio_t'(4 * 32'(r.cpu)) : ratio_t'(APIC_FIXED_RATIO);
    return r;
  endfunction

  // High for the first floor(div/2) phases after the group's rising point.
  function automatic logic wave_high(input phase_t ph, input ratio_t div, input int unsigned lag);
    int unsigned pos;
    pos = (32'(ph) + FRAME_LEN - lag) % 32'(div);
    return pos < (32'(div) >> 1);
  endfunction

endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_in,
  input  logic   stop_in,
  output phase_t phase,
  output logic   cfg_fast,
  output logic   cfg_run
);

  logic frame_end;
  assign frame_end = (phase == phase_t'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      cfg_fast <= 1'b0;
      cfg_run  <= 1'b0;
    end else begin
      phase <= frame_end ? '0 : phase + 1'b1;
      if (frame_end) begin
        cfg_fast <= sel_in;
        cfg_run  <= ~stop_in;
      end
    end
  end

  AST_SEL_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(cfg_fast));  // R9
  AST_RUN_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(cfg_run));  // R10

endmodule

// File: rtl/clkdiv_wave.sv
module clkdiv_wave
  import clkdiv_pkg::*;
#(
  parameter int unsigned LAG     = 0,
  parameter bit          STRETCH = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  phase_t phase,
  input  ratio_t ratio,
  output logic   lead,
  output logic   wave
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lead <= 1'b0;
    else        lead <= run & wave_high(phase, ratio, LAG);
  end

  AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !lead);  // R10

  if (STRETCH) begin : g_odd
    logic odd_q;
    logic stretch_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) odd_q <= 1'b0;
      else        odd_q <= ratio[0];
    end

    // Half-cycle extension so an odd ratio keeps an even duty.
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) stretch_q <= 1'b0;
      else        stretch_q <= lead & odd_q;
    end

    assign wave = lead | stretch_q;

    AST_STRETCH_ODD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      stretch_q |-> odd_q);  // R5
  end else begin : g_even
    assign wave = lead;
  end

endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_CPU     = 7,
  parameter int unsigned NUM_MEM     = 2,
  parameter int unsigned NUM_P66     = 4,
  parameter int unsigned NUM_P33     = 2,
  parameter int unsigned NUM_APIC    = 7,
  parameter int unsigned NUM_OPT     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_fast,
  input  logic                apic_strap,
  input  logic                wide_strap,
  input  logic                stop_req,
  output logic [NUM_CPU-1:0]  cpu_clk,
  output logic [NUM_MEM-1:0]  memref_clk,
  output logic [NUM_P66-1:0]  pci66_clk,
  output logic [NUM_P33-1:0]  pci33_clk,
  output logic [NUM_APIC-1:0] apic_clk
);

  localparam int unsigned CPU_BASE  = NUM_CPU - NUM_OPT;
  localparam int unsigned APIC_BASE = NUM_APIC - NUM_OPT;

  logic [1:0] raw_ctl;
  logic [1:0] sync_ctl;
  assign raw_ctl = {stop_req, sel_fast};

  clkdiv_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_ctl), .q(sync_ctl)
  );

  phase_t phase;
  logic   cfg_fast;
  logic   cfg_run;

  clkdiv_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sel_in(sync_ctl[0]), .stop_in(sync_ctl[1]),
    .phase(phase), .cfg_fast(cfg_fast), .cfg_run(cfg_run)
  );

  // Straps follow their pins only while reset is held.
  logic apic_q;
  logic wide_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      apic_q <= apic_strap;
      wide_q <= wide_strap;
    end
  end

  ratio_set_t rs;
  assign rs = ratios(cfg_fast, apic_q);

  logic lead_cpu, lead_mem, lead_p66, lead_p33, lead_apic;
  logic w_cpu, w_mem, w_p66, w_p33, w_apic;

  clkdiv_wave #(.LAG(0), .STRETCH(1'b1)) u_w_cpu (
    .clk(clk), .rst_n(rst_n), .run(cfg_run), .phase(phase), .ratio(rs.cpu),
    .lead(lead_cpu), .wave(w_cpu)
  );
  clkdiv_wave #(.LAG(0), .STRETCH(1'b0)) u_w_mem (
    .clk(clk), .rst_n(rst_n), .run(cfg_run), .phase(phase), .ratio(rs.mem),
    .lead(lead_mem), .wave(w_mem)
  );
  clkdiv_wave #(.LAG(0), .STRETCH(1'b0)) u_w_p66 (
    .clk(clk), .rst_n(rst_n), .run(cfg_run), .phase(phase), .ratio(rs.pci66),
    .lead(lead_p66), .wave(w_p66)
  );
  clkdiv_wave #(.LAG(LATE_LAG), .STRETCH(1'b0)) u_w_p33 (
    .clk(clk), .rst_n(rst_n), .run(cfg_run), .phase(phase), .ratio(rs.pci33),
    .lead(lead_p33), .wave(w_p33)
  );
  clkdiv_wave #(.LAG(LATE_LAG), .STRETCH(1'b0)) u_w_apic (
    .clk(clk), .rst_n(rst_n), .run(cfg_run), .phase(phase), .ratio(rs.apic),
    .lead(lead_apic), .wave(w_apic)
  );

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    if (i >= CPU_BASE) begin : g_opt
      assign cpu_clk[i] = w_cpu & wide_q;
    end else begin : g_base
      assign cpu_clk[i] = w_cpu;
    end
  end

  for (genvar i = 0; i < NUM_APIC; i++) begin : g_apic
    if (i >= APIC_BASE) begin : g_opt
      assign apic_clk[i] = w_apic & wide_q;
    end else begin : g_base
      assign apic_clk[i] = w_apic;
    end
  end

  assign memref_clk = {NUM_MEM{w_mem}};
  assign pci66_clk  = {NUM_P66{w_p66}};
  assign pci33_clk  = {NUM_P33{w_p33}};

  AST_MEM_WITH_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lead_mem) |-> $rose(lead_cpu));  // R2
  AST_P33_AFTER_P66: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lead_p33) |-> ($past(lead_p66) && !$past(lead_p66, 2)));  // R6
  AST_APIC_AFTER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lead_apic) |-> ($past(lead_cpu) && !$past(lead_cpu, 2)));  // R6
  AST_OPT_COPIES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> (cpu_clk[NUM_CPU-1 -: NUM_OPT] == '0 && apic_clk[NUM_APIC-1 -: NUM_OPT] == '0));  // R7
  AST_STRAPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(apic_q) && $stable(wide_q)));  // R8

endmodule

// File: tb/sim_clkdiv_tree.sv
module sim_clkdiv_tree;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_fast = 1'b1;
  logic apic_strap = 1'b0;
  logic wide_strap = 1'b1;
  logic stop_req = 1'b0;
  logic [6:0] cpu_clk;
  logic [1:0] memref_clk;
  logic [3:0] pci66_clk;
  logic [1:0] pci33_clk;
  logic [6:0] apic_clk;

  clkdiv_tree u0 (
    .clk(clk), .rst_n(rst_n), .sel_fast(sel_fast), .apic_strap(apic_strap),
    .wide_strap(wide_strap), .stop_req(stop_req), .cpu_clk(cpu_clk),
    .memref_clk(memref_clk), .pci66_clk(pci66_clk), .pci33_clk(pci33_clk),
    .apic_clk(apic_clk)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // group index: 0 cpu, 1 mem, 2 pci66, 3 pci33, 4 apic
  int hi_cnt [5];
  int min_iv [5];
  int max_iv [5];
  int last_r [5];
  bit prev_l [5];
  int ord_bad;
  int copy_bad;

  function automatic bit rep(input int g);
    case (g)
      0: return cpu_clk[0];
      1: return memref_clk[0];
      2: return pci66_clk[0];
      3: return pci33_clk[0];
      default: return apic_clk[0];
    endcase
  endfunction

  function automatic bit any_out();
    return |{cpu_clk, memref_clk, pci66_clk, pci33_clk, apic_clk};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int n, input bit wide);
    bit rose [5];
    for (int g = 0; g < 5; g++) begin
      hi_cnt[g] = 0; min_iv[g] = 1000; max_iv[g] = 0; last_r[g] = -10; prev_l[g] = 1'b1;
    end
    ord_bad = 0;
    copy_bad = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
      for (int g = 0; g < 5; g++) hi_cnt[g] += int'(rep(g));
      #10;
      for (int g = 0; g < 5; g++) begin
        bit cur;
        cur = rep(g);
        hi_cnt[g] += int'(cur);
        rose[g] = cur && !prev_l[g];
        if (rose[g]) begin
          if (last_r[g] >= 0) begin
            if (i - last_r[g] < min_iv[g]) min_iv[g] = i - last_r[g];
            if (i - last_r[g] > max_iv[g]) max_iv[g] = i - last_r[g];
          end
          last_r[g] = i;
        end
        prev_l[g] = cur;
      end
      if (i >= 2 && rose[3] && !(last_r[2] == i - 1 && last_r[0] == i - 1)) ord_bad++;
      if (i >= 2 && rose[4] && last_r[0] != i - 1) ord_bad++;
      for (int k = 0; k < 7; k++) begin
        if (cpu_clk[k] !== ((k >= 5 && !wide) ? 1'b0 : cpu_clk[0])) copy_bad++;
        if (apic_clk[k] !== ((k >= 5 && !wide) ? 1'b0 : apic_clk[0])) copy_bad++;
      end
      for (int k = 0; k < 4; k++) if (pci66_clk[k] !== pci66_clk[0]) copy_bad++;
      for (int k = 0; k < 2; k++) begin
        if (memref_clk[k] !== memref_clk[0]) copy_bad++;
        if (pci33_clk[k] !== pci33_clk[0]) copy_bad++;
      end
    end
  endtask

  task automatic chk_period(input int g, input int exp, input string tag);
    check(min_iv[g] == exp && max_iv[g] == exp, tag,
          (min_iv[g] != exp) ? min_iv[g] : max_iv[g], exp);
  endtask

  task automatic do_reset(input bit sel, input bit apic, input bit wide);
    @(negedge clk);
    sel_fast = sel; apic_strap = apic; wide_strap = wide; stop_req = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    sel_fast = 1'b1; apic_strap = 1'b0; wide_strap = 1'b1; stop_req = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(any_out() == 1'b0, "R11 outputs low in reset", int'(any_out()), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(any_out() == 1'b0, "R11 outputs low before first frame", int'(any_out()), 0);
    repeat (80) @(negedge clk);
    measure(48, 1'b1);
    check(hi_cnt[0] == 48, "R11 processor runs after first frame", hi_cnt[0], 48);
  endtask

  task automatic t_mode(input bit sel, input bit apic, input bit wide);
    int cpu_p;
    int apic_p;
    cpu_p  = sel ? 3 : 4;
    apic_p = apic ? 4 * cpu_p : 24;
    do_reset(sel, apic, wide);
    repeat (110) @(posedge clk);
    measure(96, wide);
    chk_period(0, cpu_p, "R1 processor period");
    chk_period(1, 2 * cpu_p, "R2 memory reference period");
    chk_period(2, 6, "R3 66 MHz period");
    chk_period(3, 12, "R3 33 MHz period");
    chk_period(4, apic_p, "R4 interrupt-controller period");
    for (int g = 0; g < 5; g++) check(hi_cnt[g] == 96, "R5 half duty", hi_cnt[g], 96);
    check(ord_bad == 0, "R6 edge order", ord_bad, 0);
    check(copy_bad == 0, "R7 copy enables", copy_bad, 0);
  endtask

  task automatic t_strap_ignore();
    do_reset(1'b1, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    apic_strap = 1'b1;
    wide_strap = 1'b1;
    repeat (70) @(posedge clk);
    measure(96, 1'b0);
    check(copy_bad == 0, "R7 late strap change ignored", copy_bad, 0);
    chk_period(4, 24, "R8 late strap change ignored");
  endtask

  task automatic t_switch();
    do_reset(1'b1, 1'b1, 1'b1);
    repeat (110) @(posedge clk);
    fork
      measure(192, 1'b1);
      begin
        repeat (70) @(negedge clk);
        sel_fast = 1'b0;
      end
    join
    check(min_iv[0] == 3 && max_iv[0] == 4, "R9 processor intervals across switch",
          min_iv[0] * 10 + max_iv[0], 34);
    check(min_iv[4] >= 12 && max_iv[4] <= 16, "R9 interrupt-controller intervals across switch",
          min_iv[4] * 100 + max_iv[4], 1216);
    chk_period(3, 12, "R9 33 MHz period across switch");
    check(ord_bad == 0, "R9 R6 edge order across switch", ord_bad, 0);
    repeat (60) @(posedge clk);
    measure(96, 1'b1);
    chk_period(0, 4, "R9 processor period after switch");
    chk_period(4, 16, "R9 interrupt-controller period after switch");
  endtask

  task automatic t_stop();
    int hsum;
    do_reset(1'b0, 1'b0, 1'b1);
    repeat (110) @(posedge clk);
    @(negedge clk);
    stop_req = 1'b1;
    repeat (60) @(posedge clk);
    measure(96, 1'b1);
    hsum = 0;
    for (int g = 0; g < 5; g++) hsum += hi_cnt[g];
    check(hsum == 0, "R10 outputs low while stopped", hsum, 0);
    @(negedge clk);
    stop_req = 1'b0;
    repeat (60) @(posedge clk);
    measure(96, 1'b1);
    chk_period(0, 4, "R10 processor resumes");
    check(hi_cnt[3] == 96, "R10 33 MHz resumes", hi_cnt[3], 96);
  endtask

  initial begin
    t_reset();
    t_mode(1'b1, 1'b0, 1'b1);
    t_mode(1'b0, 1'b0, 1'b1);
    t_mode(1'b1, 1'b1, 1'b0);
    t_mode(1'b0, 1'b1, 1'b0);
    t_strap_ignore();
    t_switch();
    t_stop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R1: actual %0d expected %0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule